// File: doc/BRIEF.md
# Debug ROM Fetch Tracker

This block sits on the fetch path of one or more harts that are parked in debug mode. It serves a small instruction window with three regions. The first is an entry region with one 32-bit word per hart. The second is a two-word code region. The third is an exception region with one word per hart. The block learns the debug state only from which of these words the harts fetch. A hart that fetches its entry word is halted. A jump-to-self in the selected hart's entry word means the outstanding command has finished. A debug-return in code word 0 means the hart has resumed. A fetch from the exception region reports a failed command.

A command engine beside the block places instruction words into the regions and into a pending-action register, and raises the busy flag when it starts a command. When the selected hart fetches an entry word that is not the idle loop, an action is dispatched. The next fetch outside the entry region then patches the pending-action word, which is jump-to-self by default, back into that hart's entry slot. The pending-action register returns to jump-to-self at the same time.

The control core is a two-state machine. ST_IDLE means no dispatched action is outstanding. ST_ACTED means an action was dispatched and the idle loop still has to be restored. The transition IDLE to ACTED happens on an entry fetch while the selected hart's entry word is not jump-to-self. The transition ACTED to IDLE happens on any fetch outside the entry region, and that fetch performs the restore. Any other cycle keeps the current state.

Top module: `dbg_fetch_tracker`

## Requirements
- R1: After synchronous active-high reset the following hold: every entry word and the pending-action word are jump-to-self (32'h0000006F), code and exception words are zero, halted is all zero, busy is 0, cmd_err is 0 and fetch_err is 0.
- R2: A fetch returns the addressed word on fetch_rdata one cycle later, and the value is held until the next fetch. Bits [7:0] are the byte at the lowest address (little-endian). Address bits [1:0] are ignored. The entry region is at 12'h400 + 4*hart, the code region at 12'h300/12'h304, and the exception region at 12'h500 + 4*hart.
- R3: A fetch from the entry region sets halted for the hart whose word was fetched.
- R4: An entry-region fetch while the selected hart's entry word equals 32'h0000006F clears busy.
- R5: An entry-region fetch while the selected hart's entry word differs from jump-to-self enters ST_ACTED. The next fetch outside the entry region writes the pending-action word into the selected hart's entry word and resets the pending-action word to jump-to-self.
- R6: A code-region fetch while code word 0 equals 32'h7B200073 clears busy and clears halted for the selected hart.
- R7: An exception-region fetch sets cmd_err to 3 only when cmd_err is 0 (none). err_clear sets cmd_err to 0.
- R8: A fetch outside all regions returns zero and raises fetch_err for exactly one cycle.
- R9: An engine write stores eng_wr_data into the word chosen by eng_wr_region (0 entry, 1 code, 2 exception, 3 pending-action) and eng_wr_index. The new value is visible to the next fetch.
- R10: The following same-cycle rules apply. eng_busy_set wins over a completion that clears busy. An engine write wins over a restore of the same entry word or of the pending-action word. err_clear is applied before the exception rule, so both together give cmd_err 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_hart | input | 2 | Hart currently selected by the debugger |
| fetch_valid | input | 1 | A fetch into the window this cycle |
| fetch_addr | input | 12 | Byte address of the fetch |
| fetch_rdata | output | 32 | Fetched word, one cycle after the fetch |
| fetch_err | output | 1 | One-cycle pulse after a fetch that hit no region |
| eng_wr_valid | input | 1 | Command engine word write |
| eng_wr_region | input | 2 | Target: 0 entry, 1 code, 2 exception, 3 pending-action |
| eng_wr_index | input | 2 | Word index inside the target region |
| eng_wr_data | input | 32 | Word to store |
| eng_busy_set | input | 1 | Command engine starts a command |
| err_clear | input | 1 | Return cmd_err to none |
| busy | output | 1 | A command is outstanding |
| cmd_err | output | 3 | Command error code (0 none, 3 exception) |
| halted | output | 4 | Per-hart halted flags |

## Verification
Two pairs of functions can act in the same cycle. The command engine can raise busy in the very cycle that an idle-loop fetch reports completion. An engine write to the selected entry word can also meet the restore carried out by a fetch outside the entry region. The bench drives both inputs in one cycle for each pair. It then judges the outcome at the ports. For the first pair it reads busy one cycle later. For the second pair it fetches the entry word again and compares it with the engine's value, and a second dispatch and restore then shows that the pending-action word had returned to jump-to-self.

// File: rtl/dfw_pkg.sv
package dfw_pkg;

    localparam logic [31:0] INSN_JSELF = 32'h0000006F;
    localparam logic [31:0] INSN_DRET  = 32'h7B200073;

    localparam logic [2:0] CERR_NONE = 3'd0;
    localparam logic [2:0] CERR_EXC  = 3'd3;

    typedef enum logic [1:0] {
        RGN_ENTRY = 2'd0,
        RGN_CODE  = 2'd1,
        RGN_EXC   = 2'd2,
        RGN_PEND  = 2'd3
    } rgn_e;

    typedef enum logic [1:0] {
        HIT_NONE  = 2'd0,
        HIT_ENTRY = 2'd1,
        HIT_CODE  = 2'd2,
        HIT_EXC   = 2'd3
    } hit_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ACTED = 1'b1
    } dfw_state_e;

endpackage

// File: rtl/dfw_decode.sv
module dfw_decode
    import dfw_pkg::*;
#(
    parameter int AW         = 12,
    parameter int NUM_HARTS  = 4,
    parameter int IW         = 2,
    parameter int ENTRY_BASE = 'h400,
    parameter int CODE_BASE  = 'h300,
    parameter int EXC_BASE   = 'h500
) (
    input  logic [AW-1:0] addr,
    output hit_e          hit,
    output logic [IW-1:0] word_idx
);
    localparam int HART_BYTES = 4 * NUM_HARTS;
    localparam int CODE_BYTES = 8;

    logic [AW-1:0] off_entry;
    logic [AW-1:0] off_code;
    logic [AW-1:0] off_exc;
    logic          in_entry;
    logic          in_code;
    logic          in_exc;

    always_comb begin
        off_entry = addr - AW'(ENTRY_BASE);
        off_code  = addr - AW'(CODE_BASE);
        off_exc   = addr - AW'(EXC_BASE);
        in_entry  = (addr >= AW'(ENTRY_BASE)) && (int'(off_entry) < HART_BYTES);
        in_code   = (addr >= AW'(CODE_BASE))  && (int'(off_code)  < CODE_BYTES);
        in_exc    = (addr >= AW'(EXC_BASE))   && (int'(off_exc)   < HART_BYTES);
        hit       = HIT_NONE;
        word_idx  = '0;
        if (in_entry) begin
            hit      = HIT_ENTRY;
            word_idx = IW'(off_entry >> 2);
        end else if (in_code) begin
            hit      = HIT_CODE;
            word_idx = IW'(off_code >> 2);
        end else if (in_exc) begin
            hit      = HIT_EXC;
            word_idx = IW'(off_exc >> 2);
        end
    end
endmodule

// File: rtl/dfw_store.sv
module dfw_store
    import dfw_pkg::*;
#(
    parameter int NUM_HARTS = 4,
    parameter int IW        = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          eng_we,
    input  rgn_e          eng_rgn,
    input  logic [IW-1:0] eng_idx,
    input  logic [31:0]   eng_data,
    input  logic          rest_en,
    input  logic [IW-1:0] rest_idx,
    input  hit_e          rd_hit,
    input  logic [IW-1:0] rd_idx,
    input  logic [IW-1:0] sel_idx,
    output logic [31:0]   rd_data,
    output logic [31:0]   sel_entry,
    output logic [31:0]   code0
);
    logic [31:0] entry_q [NUM_HARTS];
    logic [31:0] exc_q   [NUM_HARTS];
    logic [31:0] code_q  [2];
    logic [31:0] pend_q;

    genvar g;
    generate
        for (g = 0; g < NUM_HARTS; g++) begin : g_hart
            logic eng_hit_entry;
            logic eng_hit_exc;
            assign eng_hit_entry = eng_we && (eng_rgn == RGN_ENTRY) && (int'(eng_idx) == g);
            assign eng_hit_exc   = eng_we && (eng_rgn == RGN_EXC)   && (int'(eng_idx) == g);

            always_ff @(posedge clk) begin
                if (rst) begin
                    entry_q[g] <= INSN_JSELF;
                end else if (eng_hit_entry) begin
                    entry_q[g] <= eng_data;
                end else if (rest_en && (int'(rest_idx) == g)) begin
                    entry_q[g] <= pend_q;
                end
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    exc_q[g] <= '0;
                end else if (eng_hit_exc) begin
                    exc_q[g] <= eng_data;
                end
            end
        end

        for (g = 0; g < 2; g++) begin : g_code
            always_ff @(posedge clk) begin
                if (rst) begin
                    code_q[g] <= '0;
                end else if (eng_we && (eng_rgn == RGN_CODE) && (int'(eng_idx) == g)) begin
                    code_q[g] <= eng_data;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= INSN_JSELF;
        end else if (eng_we && (eng_rgn == RGN_PEND)) begin
            pend_q <= eng_data;
        end else if (rest_en) begin
            pend_q <= INSN_JSELF;
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_hit)
            HIT_ENTRY: rd_data = (int'(rd_idx) < NUM_HARTS) ? entry_q[rd_idx] : '0;
            HIT_CODE:  rd_data = code_q[rd_idx[0]];
            HIT_EXC:   rd_data = (int'(rd_idx) < NUM_HARTS) ? exc_q[rd_idx] : '0;
            HIT_NONE:  rd_data = '0;
        endcase
        sel_entry = (int'(sel_idx) < NUM_HARTS) ? entry_q[sel_idx] : INSN_JSELF;
        code0     = code_q[0];
    end

    a_r9_code_write: assert property (@(posedge clk) disable iff (rst)
        (eng_we && eng_rgn == RGN_CODE && eng_idx == '0) |=> (code_q[0] == $past(eng_data)));

    a_r5_pend_reload: assert property (@(posedge clk) disable iff (rst)
        (rest_en && !(eng_we && eng_rgn == RGN_PEND)) |=> (pend_q == INSN_JSELF));
endmodule

// File: rtl/dfw_ctrl.sv
module dfw_ctrl
    import dfw_pkg::*;
#(
    parameter int NUM_HARTS = 4,
    parameter int IW        = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [IW-1:0]        sel_hart,
    input  logic                 fetch_valid,
    input  hit_e                 hit,
    input  logic [IW-1:0]        word_idx,
    input  logic [31:0]          rd_data,
    input  logic [31:0]          sel_entry,
    input  logic [31:0]          code0,
    input  logic                 busy_set,
    input  logic                 err_clear,
    output logic                 rest_en,
    output logic [IW-1:0]        rest_idx,
    output logic [31:0]          fetch_rdata,
    output logic                 fetch_err,
    output logic                 busy,
    output logic [2:0]           cmd_err,
    output logic [NUM_HARTS-1:0] halted
);
    dfw_state_e           state_q, state_d;
    logic                 busy_q, busy_d;
    logic [2:0]           cerr_q, cerr_d, cerr_base;
    logic [NUM_HARTS-1:0] halt_q, halt_d;
    logic [31:0]          rdata_q;
    logic                 err_q;

    logic sel_ok, entry_f, code_f, exc_f, miss_f, outside_f, sel_idle, resume_f;

    always_comb begin
        sel_ok    = int'(sel_hart) < NUM_HARTS;
        entry_f   = fetch_valid && (hit == HIT_ENTRY);
        code_f    = fetch_valid && (hit == HIT_CODE);
        exc_f     = fetch_valid && (hit == HIT_EXC);
        miss_f    = fetch_valid && (hit == HIT_NONE);
        outside_f = fetch_valid && (hit != HIT_ENTRY);
        sel_idle  = sel_entry == INSN_JSELF;
        resume_f  = code_f && (code0 == INSN_DRET);
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (entry_f && !sel_idle) state_d = ST_ACTED;
            ST_ACTED: if (outside_f)            state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        rest_en  = (state_q == ST_ACTED) && outside_f && sel_ok;
        rest_idx = sel_hart;

        busy_d = busy_q;
        if ((entry_f && sel_idle) || resume_f) busy_d = 1'b0;
        if (busy_set)                          busy_d = 1'b1;

        halt_d = halt_q;
        if (entry_f && int'(word_idx) < NUM_HARTS) halt_d[word_idx] = 1'b1;
        if (resume_f && sel_ok)                    halt_d[sel_hart] = 1'b0;

        cerr_base = err_clear ? CERR_NONE : cerr_q;
        cerr_d    = cerr_base;
        if (exc_f && cerr_base == CERR_NONE) cerr_d = CERR_EXC;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            cerr_q  <= CERR_NONE;
            halt_q  <= '0;
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            busy_q <= busy_d;
            cerr_q <= cerr_d;
            halt_q <= halt_d;
            err_q  <= miss_f;
            if (fetch_valid) rdata_q <= miss_f ? '0 : rd_data;
        end
    end

    assign fetch_rdata = rdata_q;
    assign fetch_err   = err_q;
    assign busy        = busy_q;
    assign cmd_err     = cerr_q;
    assign halted      = halt_q;

    a_r8_err_pulse: assert property (@(posedge clk) disable iff (rst)
        fetch_err |-> (fetch_rdata == '0) && $past(fetch_valid));

    a_r4_busy_drop: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_q) |-> $past(fetch_valid) && !$past(busy_set));

    a_r7_err_sticky: assert property (@(posedge clk) disable iff (rst)
        (cerr_q == CERR_EXC && !err_clear) |=> (cerr_q == CERR_EXC));

    a_r5_leave_acted: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ACTED && outside_f) |=> (state_q == ST_IDLE));

    a_r3_halt_rise: assert property (@(posedge clk) disable iff (rst)
        ($countones(halt_q) > $countones($past(halt_q))) |-> $past(entry_f));

    a_r10_busy_set_wins: assert property (@(posedge clk) disable iff (rst)
        busy_set |=> busy_q);
endmodule

// File: rtl/dbg_fetch_tracker.sv
module dbg_fetch_tracker
    import dfw_pkg::*;
#(
    parameter int AW         = 12,
    parameter int NUM_HARTS  = 4,
    parameter int ENTRY_BASE = 'h400,
    parameter int CODE_BASE  = 'h300,
    parameter int EXC_BASE   = 'h500,
    localparam int IW        = (NUM_HARTS > 2) ? $clog2(NUM_HARTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [IW-1:0]        sel_hart,
    input  logic                 fetch_valid,
    input  logic [AW-1:0]        fetch_addr,
    output logic [31:0]          fetch_rdata,
    output logic                 fetch_err,
    input  logic                 eng_wr_valid,
    input  logic [1:0]           eng_wr_region,
    input  logic [IW-1:0]        eng_wr_index,
    input  logic [31:0]          eng_wr_data,
    input  logic                 eng_busy_set,
    input  logic                 err_clear,
    output logic                 busy,
    output logic [2:0]           cmd_err,
    output logic [NUM_HARTS-1:0] halted
);
    hit_e          hit;
    logic [IW-1:0] word_idx;
    logic [31:0]   rd_data;
    logic [31:0]   sel_entry;
    logic [31:0]   code0;
    logic          rest_en;
    logic [IW-1:0] rest_idx;
    rgn_e          eng_rgn;

    assign eng_rgn = rgn_e'(eng_wr_region);

    dfw_decode #(
        .AW(AW), .NUM_HARTS(NUM_HARTS), .IW(IW),
        .ENTRY_BASE(ENTRY_BASE), .CODE_BASE(CODE_BASE), .EXC_BASE(EXC_BASE)
    ) u_decode (
        .addr     (fetch_addr),
        .hit      (hit),
        .word_idx (word_idx)
    );

    dfw_store #(.NUM_HARTS(NUM_HARTS), .IW(IW)) u_store (
        .clk       (clk),
        .rst       (rst),
        .eng_we    (eng_wr_valid),
        .eng_rgn   (eng_rgn),
        .eng_idx   (eng_wr_index),
        .eng_data  (eng_wr_data),
        .rest_en   (rest_en),
        .rest_idx  (rest_idx),
        .rd_hit    (fetch_valid ? hit : HIT_NONE),
        .rd_idx    (word_idx),
        .sel_idx   (sel_hart),
        .rd_data   (rd_data),
        .sel_entry (sel_entry),
        .code0     (code0)
    );

    dfw_ctrl #(.NUM_HARTS(NUM_HARTS), .IW(IW)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .sel_hart    (sel_hart),
        .fetch_valid (fetch_valid),
        .hit         (hit),
        .word_idx    (word_idx),
        .rd_data     (rd_data),
        .sel_entry   (sel_entry),
        .code0       (code0),
        .busy_set    (eng_busy_set),
        .err_clear   (err_clear),
        .rest_en     (rest_en),
        .rest_idx    (rest_idx),
        .fetch_rdata (fetch_rdata),
        .fetch_err   (fetch_err),
        .busy        (busy),
        .cmd_err     (cmd_err),
        .halted      (halted)
    );

    a_r2_entry_read: assert property (@(posedge clk) disable iff (rst)
        (fetch_valid && hit == HIT_ENTRY && word_idx == sel_hart && !rest_en)
            |=> (fetch_rdata == $past(sel_entry)));
endmodule

// File: tb/tb_dbg_fetch_tracker.sv
module tb_dbg_fetch_tracker;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  sel_hart;
    logic        fetch_valid;
    logic [11:0] fetch_addr;
    logic [31:0] fetch_rdata;
    logic        fetch_err;
    logic        eng_wr_valid;
    logic [1:0]  eng_wr_region;
    logic [1:0]  eng_wr_index;
    logic [31:0] eng_wr_data;
    logic        eng_busy_set;
    logic        err_clear;
    logic        busy;
    logic [2:0]  cmd_err;
    logic [3:0]  halted;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #(CLK_P/2) clk = ~clk;

    dbg_fetch_tracker dut (
        .clk(clk), .rst(rst), .sel_hart(sel_hart),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .fetch_rdata(fetch_rdata), .fetch_err(fetch_err),
        .eng_wr_valid(eng_wr_valid), .eng_wr_region(eng_wr_region),
        .eng_wr_index(eng_wr_index), .eng_wr_data(eng_wr_data),
        .eng_busy_set(eng_busy_set), .err_clear(err_clear),
        .busy(busy), .cmd_err(cmd_err), .halted(halted)
    );

    typedef struct packed {
        logic [1:0]  kind;   // 0 fetch, 1 engine write, 2 busy set
        logic [1:0]  rgn;
        logic [1:0]  idx;
        logic [11:0] addr;
        logic [31:0] data;
        logic [31:0] x_rd;
        logic        x_err;
        logic        x_busy;
        logic [3:0]  x_halt;
        logic [2:0]  x_cerr;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 2'd0, 2'd0, 12'h404, 32'h0,        32'h6F,       1'b0, 1'b0, 4'b0010, 3'd0},
        '{2'd1, 2'd1, 2'd0, 12'h0,   32'h12345678, 32'h0,        1'b0, 1'b0, 4'b0010, 3'd0},
        '{2'd0, 2'd0, 2'd0, 12'h300, 32'h0,        32'h12345678, 1'b0, 1'b0, 4'b0010, 3'd0},
        '{2'd0, 2'd0, 2'd0, 12'h302, 32'h0,        32'h12345678, 1'b0, 1'b0, 4'b0010, 3'd0},
        '{2'd2, 2'd0, 2'd0, 12'h0,   32'h0,        32'h0,        1'b0, 1'b1, 4'b0010, 3'd0},
        '{2'd0, 2'd0, 2'd0, 12'h404, 32'h0,        32'h6F,       1'b0, 1'b0, 4'b0010, 3'd0},
        '{2'd0, 2'd0, 2'd0, 12'h40C, 32'h0,        32'h6F,       1'b0, 1'b0, 4'b1010, 3'd0},
        '{2'd1, 2'd0, 2'd1, 12'h0,   32'hDEADBEEF, 32'h0,        1'b0, 1'b0, 4'b1010, 3'd0},
        '{2'd2, 2'd0, 2'd0, 12'h0,   32'h0,        32'h0,        1'b0, 1'b1, 4'b1010, 3'd0},
        '{2'd0, 2'd0, 2'd0, 12'h404, 32'h0,        32'hDEADBEEF, 1'b0, 1'b1, 4'b1010, 3'd0},
        '{2'd0, 2'd0, 2'd0, 12'h304, 32'h0,        32'h0,        1'b0, 1'b1, 4'b1010, 3'd0},
        '{2'd0, 2'd0, 2'd0, 12'h404, 32'h0,        32'h6F,       1'b0, 1'b0, 4'b1010, 3'd0},
        '{2'd1, 2'd1, 2'd0, 12'h0,   32'h7B200073, 32'h0,        1'b0, 1'b0, 4'b1010, 3'd0},
        '{2'd2, 2'd0, 2'd0, 12'h0,   32'h0,        32'h0,        1'b0, 1'b1, 4'b1010, 3'd0},
        '{2'd0, 2'd0, 2'd0, 12'h300, 32'h0,        32'h7B200073, 1'b0, 1'b0, 4'b1000, 3'd0},
        '{2'd0, 2'd0, 2'd0, 12'h500, 32'h0,        32'h0,        1'b0, 1'b0, 4'b1000, 3'd3},
        '{2'd0, 2'd0, 2'd0, 12'h600, 32'h0,        32'h0,        1'b1, 1'b0, 4'b1000, 3'd3},
        '{2'd0, 2'd0, 2'd0, 12'h404, 32'h0,        32'h6F,       1'b0, 1'b0, 4'b1010, 3'd3}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        fetch_valid   = 1'b0;
        fetch_addr    = '0;
        eng_wr_valid  = 1'b0;
        eng_wr_region = '0;
        eng_wr_index  = '0;
        eng_wr_data   = '0;
        eng_busy_set  = 1'b0;
        err_clear     = 1'b0;
    endtask

    // inputs set at a negedge, captured at the following posedge, checked at the next negedge
    task automatic tick();
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic fetch(input logic [11:0] a);
        fetch_valid = 1'b1;
        fetch_addr  = a;
        tick();
    endtask

    task automatic ewrite(input logic [1:0] r, input logic [1:0] i, input logic [31:0] d);
        eng_wr_valid  = 1'b1;
        eng_wr_region = r;
        eng_wr_index  = i;
        eng_wr_data   = d;
        tick();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        idle_inputs();
        sel_hart = 2'd1;
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 busy", 32'(busy), 32'd0);
        chk("R1 halted", 32'(halted), 32'd0);
        chk("R1 cmd_err", 32'(cmd_err), 32'd0);
        chk("R1 fetch_err", 32'(fetch_err), 32'd0);

        // table walk: R2 R3 R4 R5 R6 R7 R8 R9
        for (int v = 0; v < NV; v++) begin
            unique case (VEC[v].kind)
                2'd0: fetch(VEC[v].addr);
                2'd1: ewrite(VEC[v].rgn, VEC[v].idx, VEC[v].data);
                default: begin eng_busy_set = 1'b1; tick(); end
            endcase
            if (VEC[v].kind == 2'd0) chk($sformatf("R2 vec%0d rdata", v), fetch_rdata, VEC[v].x_rd);
            chk($sformatf("R8 vec%0d err", v), 32'(fetch_err), 32'(VEC[v].x_err));
            chk($sformatf("R4 R6 vec%0d busy", v), 32'(busy), 32'(VEC[v].x_busy));
            chk($sformatf("R3 vec%0d halted", v), 32'(halted), 32'(VEC[v].x_halt));
            chk($sformatf("R7 vec%0d cmd_err", v), 32'(cmd_err), 32'(VEC[v].x_cerr));
        end
        chk("R2 little-endian low byte", 32'(fetch_rdata[7:0]), 32'h6F);

        // R7 clear, clear with exception in the same cycle, sticky error
        err_clear = 1'b1; tick();
        chk("R7 clear", 32'(cmd_err), 32'd0);
        err_clear = 1'b1; fetch(12'h504);
        chk("R10 clear plus exception", 32'(cmd_err), 32'd3);
        fetch(12'h500);
        chk("R7 sticky", 32'(cmd_err), 32'd3);

        // R10 busy set meets completion
        eng_busy_set = 1'b1; fetch(12'h404);
        chk("R10 busy set wins", 32'(busy), 32'd1);
        fetch(12'h404);
        chk("R4 completion", 32'(busy), 32'd0);

        // R10 engine write meets restore on the same entry word
        ewrite(2'd0, 2'd1, 32'h00000001);
        fetch(12'h404);
        chk("R5 dispatched word", fetch_rdata, 32'h00000001);
        eng_wr_valid = 1'b1; eng_wr_region = 2'd0; eng_wr_index = 2'd1;
        eng_wr_data = 32'hBBBB0002; fetch(12'h304);
        fetch(12'h404);
        chk("R10 engine write wins", fetch_rdata, 32'hBBBB0002);
        fetch(12'h304);
        fetch(12'h404);
        chk("R5 restore jump-to-self", fetch_rdata, 32'h0000006F);

        // R9 pending-action word written by engine, then reset by restore
        ewrite(2'd3, 2'd0, 32'h0000A06F);
        ewrite(2'd0, 2'd1, 32'h00000001);
        fetch(12'h404);
        fetch(12'h304);
        fetch(12'h404);
        chk("R9 pending restored", fetch_rdata, 32'h0000A06F);
        fetch(12'h304);
        fetch(12'h404);
        chk("R5 pending back to idle", fetch_rdata, 32'h0000006F);

        // R8 one-cycle error
        fetch(12'h700);
        chk("R8 miss err", 32'(fetch_err), 32'd1);
        chk("R8 miss data", fetch_rdata, 32'd0);
        tick();
        chk("R8 err drops", 32'(fetch_err), 32'd0);

        // R1 reset restores contents
        ewrite(2'd0, 2'd1, 32'h00000005);
        rst = 1'b1; tick(); rst = 1'b0;
        chk("R1 halted after reset", 32'(halted), 32'd0);
        chk("R1 cmd_err after reset", 32'(cmd_err), 32'd0);
        fetch(12'h404);
        chk("R1 entry after reset", fetch_rdata, 32'h0000006F);

        finish_run();
    end
endmodule